// File: doc/BRIEF.md
# Serial ADC Command/Response Engine

This block is the digital side of a serial-interface 12-bit successive-approximation converter. It watches an active-low chip select, a serial clock and a serial data input, all sampled on the system clock. After a leading one (the start bit) it collects a mode flag and a three-bit channel field. It then drives the input-multiplexer selects and a sample/hold strobe for the analog side. When the hold window closes it captures the parallel conversion result from a behavioural converter stub and shifts that result out on a serial data output with a separate drive enable.

Each frame sends the result twice: first from the most significant bit down, then again from bit 1 upward. After that the output stays at zero for as long as the clock keeps running. The serial clock may idle low or high. Only rising clock edges carry command bits, and the output changes only on falling edges. The serial inputs must be synchronous to `clk`, and each serial clock level must be held for at least two `clk` cycles. Every output reacts one `clk` cycle after the serial edge that causes the change.

Top module: `adc_cmd_engine`

## Requirements
- R1: While the engine waits for a command with chip select low, rising serial clock edges with data-in low are ignored. The first rising edge with data-in high is the start bit.
- R2: The four rising edges after the start bit carry, in order, the mode flag (1 = single-ended, 0 = differential) and the channel field bits 2, 1 and 0. On the fourth of these edges, `chan_pos_o` takes the field value and `diff_o` takes the inverted mode flag. `chan_neg_o` takes the field with bit 0 flipped in differential mode, and zero in single-ended mode.
- R3: `sample_o` goes high on the fourth rising edge after the start bit and low on the falling edge of the fifth clock after it. It is never high while the output is enabled.
- R4: From the chip-select fall until the falling edge of the fifth clock after the start bit, `dout_oe_o` is low. On that falling edge it goes high with `dout_o` low (the null bit).
- R5: On the next twelve falling edges, `dout_o` presents result bits 11 down to 0.
- R6: On the following eleven falling edges, `dout_o` presents result bits 1 up to 11. From then on it presents zero on every falling edge while chip select stays low.
- R7: `dout_o` changes only in response to a falling serial clock edge. It keeps its value across a rising edge.
- R8: The result is captured from `result_i` on the falling edge that drives the null bit. Later changes on `result_i` do not alter the bits sent in that frame.
- R9: After reset with chip select already low, no start bit is accepted until chip select has gone high and then low again.
- R10: Chip select high forces `dout_oe_o` and `sample_o` low in the next cycle and returns the engine to idle. A new frame after such an abort runs normally. Both outputs are low after reset.
- R11: Data-in is ignored from the fifth rising edge after the start bit until chip select rises; a high level there starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock, synchronous to clk |
| din_i | input | 1 | Serial command input |
| result_i | input | RES_W (12) | Parallel conversion result from the converter stub |
| chan_pos_o | output | CH_W (3) | Positive input selected for the multiplexer |
| chan_neg_o | output | CH_W (3) | Negative input of the pair in differential mode, zero otherwise |
| diff_o | output | 1 | High for differential mode |
| sample_o | output | 1 | Sample/hold strobe, high while the input is tracked |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Drive enable for dout_o; low means high impedance |

## Verification
A wrong phase in the sequencer shows up at the ports within one serial clock. Examples are a miscounted configuration edge, a missed hold-to-null step or a bad bit index. Any of these moves the null bit or shifts the whole bit stream by a position, so the first compared falling edge after the fault disagrees with the arithmetic expectation. Corrupted channel decode appears on the multiplexer selects on the fourth rising edge, before any data is sent. A stale arming flag shows up in a different way: the drive enable rises in a frame that should stay silent. A missing abort path shows up the same way, through the drive enable or the sample strobe staying high one cycle after chip select rises.

// File: rtl/adc_eng_pkg.sv
package adc_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CFG,
        ST_HOLD,
        ST_NULL,
        ST_MSB,
        ST_LSB,
        ST_ZERO
    } eng_state_e;

    typedef struct packed {
        logic sclk;
        logic cs_n;
    } edge_regs_t;

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det
    import adc_eng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_fall_o
);

    edge_regs_t edge_d, edge_q;

    always_comb begin
        edge_d.sclk = sclk_i;
        edge_d.cs_n = cs_n_i;
    end

    // cs_n resets to 0 so a select held low through reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign sclk_rise_o = sclk_i & ~edge_q.sclk;
    assign sclk_fall_o = ~sclk_i & edge_q.sclk;
    assign cs_fall_o   = ~cs_n_i & edge_q.cs_n;

endmodule

// File: rtl/adc_cfg_decode.sv
module adc_cfg_decode #(
    parameter int unsigned CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_i,
    input  logic            commit_i,
    input  logic            din_i,
    output logic [CH_W-1:0] chan_pos_o,
    output logic [CH_W-1:0] chan_neg_o,
    output logic            diff_o
);

    localparam int unsigned CFG_N = CH_W + 1;

    typedef struct packed {
        logic [CH_W-1:0] sr;
        logic [CH_W-1:0] pos;
        logic [CH_W-1:0] neg;
        logic            diff;
    } cfg_regs_t;

    cfg_regs_t cfg_d, cfg_q;
    logic [CFG_N-1:0] word;

    always_comb begin
        cfg_d = cfg_q;
        word  = {cfg_q.sr, din_i};
        if (shift_i) begin
            cfg_d.sr = word[CH_W-1:0];
        end
        if (commit_i) begin
            cfg_d.diff = ~word[CFG_N-1];
            cfg_d.pos  = word[CH_W-1:0];
            cfg_d.neg  = word[CFG_N-1] ? '0 : (word[CH_W-1:0] ^ CH_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign chan_pos_o = cfg_q.pos;
    assign chan_neg_o = cfg_q.neg;
    assign diff_o     = cfg_q.diff;

endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RES_W-1:0] result_i,
    output logic [RES_W-1:0] hold_o
);

    logic [RES_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = load_i ? result_i : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/adc_cmd_engine.sv
module adc_cmd_engine
    import adc_eng_pkg::*;
#(
    parameter int unsigned RES_W = 12,
    parameter int unsigned CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             din_i,
    input  logic [RES_W-1:0] result_i,
    output logic [CH_W-1:0]  chan_pos_o,
    output logic [CH_W-1:0]  chan_neg_o,
    output logic             diff_o,
    output logic             sample_o,
    output logic             dout_o,
    output logic             dout_oe_o
);

    localparam int unsigned IDX_W = $clog2(RES_W);
    localparam int unsigned CNT_W = $clog2(CH_W + 1);

    typedef struct packed {
        eng_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] ccnt;
        logic             late;
        logic             sample;
        logic             oe;
        logic             dout;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;

    logic             rise, fall, cs_fall;
    logic             cfg_shift, cfg_commit, res_load;
    logic [RES_W-1:0] res_hold;
    logic [IDX_W-1:0] idx_dn, idx_up;

    adc_edge_det u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .cs_n_i      (cs_n_i),
        .sclk_rise_o (rise),
        .sclk_fall_o (fall),
        .cs_fall_o   (cs_fall)
    );

    adc_cfg_decode #(.CH_W(CH_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (cfg_shift),
        .commit_i   (cfg_commit),
        .din_i      (din_i),
        .chan_pos_o (chan_pos_o),
        .chan_neg_o (chan_neg_o),
        .diff_o     (diff_o)
    );

    adc_result_hold #(.RES_W(RES_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (res_load),
        .result_i (result_i),
        .hold_o   (res_hold)
    );

    assign idx_dn = ctl_q.idx - IDX_W'(1);
    assign idx_up = ctl_q.idx + IDX_W'(1);

    always_comb begin
        ctl_d      = ctl_q;
        cfg_shift  = 1'b0;
        cfg_commit = 1'b0;
        res_load   = 1'b0;
        if (cs_n_i) begin
            ctl_d.st     = ST_IDLE;
            ctl_d.sample = 1'b0;
            ctl_d.oe     = 1'b0;
            ctl_d.late   = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (cs_fall) ctl_d.st = ST_ARMED;
                end
                ST_ARMED: begin
                    if (rise && din_i) begin
                        ctl_d.st   = ST_CFG;
                        ctl_d.ccnt = '0;
                    end
                end
                ST_CFG: begin
                    if (rise) begin
                        cfg_shift = 1'b1;
                        if (ctl_q.ccnt == CNT_W'(CH_W)) begin
                            cfg_commit   = 1'b1;
                            ctl_d.st     = ST_HOLD;
                            ctl_d.sample = 1'b1;
                            ctl_d.late   = 1'b0;
                        end else begin
                            ctl_d.ccnt = ctl_q.ccnt + CNT_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    // window spans the rest of this clock and the next one
                    if (rise) begin
                        ctl_d.late = 1'b1;
                    end else if (fall && ctl_q.late) begin
                        ctl_d.st     = ST_NULL;
                        ctl_d.sample = 1'b0;
                        ctl_d.oe     = 1'b1;
                        ctl_d.dout   = 1'b0;
                        res_load     = 1'b1;
                    end
                end
                ST_NULL: begin
                    if (fall) begin
                        ctl_d.st   = ST_MSB;
                        ctl_d.idx  = IDX_W'(RES_W - 1);
                        ctl_d.dout = res_hold[RES_W-1];
                    end
                end
                ST_MSB: begin
                    if (fall) begin
                        if (ctl_q.idx == '0) begin
                            ctl_d.st   = ST_LSB;
                            ctl_d.idx  = IDX_W'(1);
                            ctl_d.dout = res_hold[1];
                        end else begin
                            ctl_d.idx  = idx_dn;
                            ctl_d.dout = res_hold[idx_dn];
                        end
                    end
                end
                ST_LSB: begin
                    if (fall) begin
                        if (ctl_q.idx == IDX_W'(RES_W - 1)) begin
                            ctl_d.st   = ST_ZERO;
                            ctl_d.dout = 1'b0;
                        end else begin
                            ctl_d.idx  = idx_up;
                            ctl_d.dout = res_hold[idx_up];
                        end
                    end
                end
                ST_ZERO: begin
                    if (fall) ctl_d.dout = 1'b0;
                end
                default: begin
                    ctl_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
        end else begin
            ctl_q      <= ctl_d;
        end
    end

    assign sample_o  = ctl_q.sample;
    assign dout_oe_o = ctl_q.oe;
    assign dout_o    = ctl_q.dout;

endmodule

// File: rtl/adc_cmd_engine_chk.sv
module adc_cmd_engine_chk #(
    parameter int unsigned CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n_i,
    input logic            sclk_i,
    input logic [CH_W-1:0] chan_pos_o,
    input logic            sample_o,
    input logic            dout_o,
    input logic            dout_oe_o
);

    a_r10_select_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (!dout_oe_o && !sample_o));

    a_r4_enable_with_null: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe_o) |-> !dout_o);

    a_r3_window_opens_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> ($past(sclk_i) && !$past(sclk_i, 2)));

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && dout_oe_o));

    a_r7_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_o) |-> (!$past(sclk_i) && $past(sclk_i, 2)));

    a_r2_select_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_pos_o) |-> ($past(sclk_i) && !$past(sclk_i, 2)));

endmodule

bind adc_cmd_engine adc_cmd_engine_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .sclk_i     (sclk_i),
    .chan_pos_o (chan_pos_o),
    .sample_o   (sample_o),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o)
);

// File: tb/sim_adc_cmd_engine.sv
`timescale 1ns/1ps
module sim_adc_cmd_engine;

    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] result = '0;
    logic [2:0]  chan_pos, chan_neg;
    logic        diff, sample, dout, dout_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_cmd_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .din_i      (din),
        .result_i   (result),
        .chan_pos_o (chan_pos),
        .chan_neg_o (chan_neg),
        .diff_o     (diff),
        .sample_o   (sample),
        .dout_o     (dout),
        .dout_oe_o  (dout_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 2 = output not driven
    function automatic int exp_out(input logic [11:0] r, input int j);
        if (j < 5)   return 2;
        if (j == 5)  return 0;
        if (j <= 17) return int'(r[17 - j]);
        if (j <= 28) return int'(r[j - 17]);
        return 0;
    endfunction

    task automatic run_frame(input bit idle_high, input int lead, input bit sgl,
                             input logic [2:0] fld, input logic [11:0] res,
                             input bit change_res, input int abort_at, input bit dead);
        int prev;
        result = res;
        if (!dead) begin
            sclk = idle_high;
            wait_h();
            cs_n = 1'b0;
            wait_h();
            if (idle_high) begin
                sclk = 1'b0;
                wait_h();
            end
        end
        for (int l = 0; l < lead; l++) begin
            din = 1'b0;
            sclk = 1'b1;
            wait_h();
            sclk = 1'b0;
            wait_h();
            check(!dout_oe && !sample, "R1 leading zero ignored", {dout_oe, sample}, 0);
        end
        prev = 2;
        for (int j = 0; j < 34; j++) begin
            int e, a;
            din = (j == 0) ? 1'b1 : (j == 1) ? sgl : (j <= 4) ? fld[4 - j] : 1'b1;
            if (change_res && j == 8) result = ~res;
            sclk = 1'b1;
            wait_h();
            check(sample == (!dead && (j == 4 || j == 5)), dead ? "R9 sample after rise" :
                  "R3 sample after rise", sample, !dead && (j == 4 || j == 5));
            a = dout_oe ? int'(dout) : 2;
            check(a == prev, "R7 output held over rise", a, prev);
            if (!dead && j == 4) begin
                check(chan_pos == fld, "R2 positive select", chan_pos, fld);
                check(diff == !sgl, "R2 mode flag", diff, !sgl);
                check(chan_neg == (sgl ? 3'd0 : (fld ^ 3'd1)), "R2 negative select",
                      chan_neg, sgl ? 0 : (fld ^ 3'd1));
            end
            sclk = 1'b0;
            wait_h();
            check(sample == (!dead && j == 4), dead ? "R9 sample after fall" :
                  "R3 sample after fall", sample, !dead && j == 4);
            e = dead ? 2 : exp_out(res, j);
            a = dout_oe ? int'(dout) : 2;
            if (dead)                       check(a == e, "R9 silent without select edge", a, e);
            else if (change_res && j > 8)   check(a == e, "R8 captured result kept", a, e);
            else if (j <= 5)                check(a == e, "R4 enable and null bit", a, e);
            else if (j <= 17)               check(a == e, "R5 msb-first bit R11", a, e);
            else                            check(a == e, "R6 lsb-first or zero R11", a, e);
            prev = a;
            if (j == abort_at) begin
                cs_n = 1'b1;
                @(negedge clk);
                @(negedge clk);
                check(!dout_oe && !sample, "R10 abort quiets outputs", {dout_oe, sample}, 0);
                break;
            end
        end
        if (idle_high) begin
            sclk = 1'b1;
            wait_h();
        end
        cs_n = 1'b1;
        wait_h();
        wait_h();
        sclk = 1'b0;
        wait_h();
    endtask

    initial begin
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_h();
        check(!dout_oe && !sample && diff == 0 && chan_pos == 0, "R10 reset state",
              {dout_oe, sample, diff}, 0);

        // sweep every mode/channel code with two results and both clock idles
        for (int code = 0; code < 16; code++) begin
            logic [11:0] r;
            r = 12'((code * 12'h111) ^ 12'h9A3);
            run_frame(1'b0, code % 6, code[3], code[2:0], r, code[0], -1, 1'b0);
            run_frame(1'b1, (code + 3) % 6, code[3], code[2:0], ~r, 1'b0, -1, 1'b0);
        end
        run_frame(1'b0, 0, 1'b1, 3'd0, 12'hFFF, 1'b0, -1, 1'b0);
        run_frame(1'b0, 2, 1'b0, 3'd7, 12'h001, 1'b0, -1, 1'b0);

        // aborts in the hold window and mid-data, each followed by a good frame
        run_frame(1'b0, 1, 1'b0, 3'd5, 12'h5A5, 1'b0, 4, 1'b0);
        run_frame(1'b0, 1, 1'b1, 3'd2, 12'h3C7, 1'b0, -1, 1'b0);
        run_frame(1'b0, 0, 1'b1, 3'd6, 12'hE18, 1'b0, 10, 1'b0);
        run_frame(1'b0, 3, 1'b0, 3'd1, 12'h7E1, 1'b0, -1, 1'b0);

        // reset with select held low: commands are ignored until a new fall
        rst_n = 1'b0;
        cs_n = 1'b0;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_h();
        run_frame(1'b0, 0, 1'b1, 3'd3, 12'hABC, 1'b0, -1, 1'b1);
        run_frame(1'b0, 0, 1'b1, 3'd3, 12'hABC, 1'b0, -1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule